// File: doc/BRIEF.md
# Acknowledge-Poll Write-Completion Sequencer

This block sits on the host side of a two-wire serial bus, above a byte-level master. It waits for a serial EEPROM to finish its self-timed internal write. A fixed worst-case delay would waste time, so the block polls the device instead. Each attempt opens a transfer with a start condition and then sends the device address with the direction bit cleared. A device that is still programming leaves the address unacknowledged. In that case the sequencer closes the transfer with a stop and tries again. A device that is ready acknowledges the address.

Once the device acknowledges, the exit path depends on what the host wants to do next. For a write, the sequencer keeps the bus and sends the memory word address at once, with no stop in between. For a read, it sends a stop and returns. The number of attempts is capped by a parameter. If the cap is reached without an acknowledge, the sequencer sends a stop and reports a timeout.

The sequencer talks to the byte master with single-cycle command strobes. It waits for a completion strobe that carries the acknowledge bit sampled on the bus. When it finishes, it pulses `done` and holds the ok/timeout status and the attempt count until the next `go`.

Top module: `ackpoll_seq`

## Requirements
- R1: After reset, `busy`, `cmd_valid`, `done`, `ok`, `timeout` are 0 and `attempts` is 0. While `busy` is 0, no command is issued, even if `cmd_done` pulses.
- R2: A `go` pulse while idle starts a run whose first command is start (code 1). `dev_addr`, `byte_addr` and `next_is_write` are captured on that cycle, and later changes to them have no effect on the run.
- R3: Each attempt is a start command (code 1) followed by a send-byte command (code 2) whose byte is `{dev_addr, 1'b0}`, that is, the direction bit in bit 0 is 0.
- R4: If the address byte completes with `cmd_ack`=0 and fewer than MAX_POLLS attempts have been made, the next command is stop (code 3), followed by a new start.
- R5: If the address byte is acknowledged and `next_is_write` was 1, the next command is send-byte with `byte_addr`, with no stop before it. The run then ends with `ok`=1.
- R6: If the address byte is acknowledged and `next_is_write` was 0, the next command is stop. The run then ends with `ok`=1.
- R7: After MAX_POLLS unacknowledged attempts, the sequencer issues a stop and ends with `timeout`=1, `ok`=0 and `attempts`=MAX_POLLS. `attempts` never exceeds MAX_POLLS.
- R8: `done` is a one-cycle pulse raised while idle. `attempts` equals the number of address bytes sent. `ok`, `timeout` and `attempts` stay unchanged until the next accepted `go`.
- R9: Every command is a single-cycle `cmd_valid` pulse. No further command is issued until `cmd_done` returns for the current one.
- R10: A `go` pulse during a run is ignored: the command sequence and the results are those of the original run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start polling (accepted only while idle) |
| next_is_write | input | 1 | 1: a write follows the poll; 0: a read follows |
| dev_addr | input | BYTE_W-1 | Device address, placed above the direction bit |
| byte_addr | input | BYTE_W | Word address sent on the write exit path |
| cmd_valid | output | 1 | One-cycle command strobe to the byte master |
| cmd_code | output | 2 | 1 start, 2 send byte and sample ACK, 3 stop |
| cmd_byte | output | BYTE_W | Byte to send with code 2 |
| cmd_done | input | 1 | Byte master finished the current command |
| cmd_ack | input | 1 | ACK sampled for a send-byte command (1 = acknowledged) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Last run ended with the device acknowledging |
| timeout | output | 1 | Last run ended at the attempt cap |
| attempts | output | $clog2(MAX_POLLS+1) | Address bytes sent in the last run |

## Verification
The bench acts as the byte master, attached to a device that stays busy for a chosen number of polls. It compares every command against a queue of expected commands. The corner cases are these:
- Zero busy polls, on both the write and the read exit. A design that adds a stop before the word address on the write exit shows up here.
- Exactly MAX_POLLS-1 busy polls. This case succeeds on the last allowed attempt, so an off-by-one limit times out here.
- Exactly MAX_POLLS busy polls, and more than that. These must time out, so a design that polls one extra time is caught.
- A second `go` and operand changes in the middle of a run, which catch a design that relatches its operands.
- A stray `cmd_done` while idle, which would start a spurious command.

The bench also varies the responder latency, which catches a design that issues a new command before the current one completes.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_START = 2'd1,
    CMD_BYTE  = 2'd2,
    CMD_STOP  = 2'd3
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ISS_START,
    ST_W_START,
    ST_ISS_ADDR,
    ST_W_ADDR,
    ST_ISS_WADDR,
    ST_W_WADDR,
    ST_ISS_STOP,
    ST_W_STOP
  } state_e;

  // what follows a completed stop
  typedef enum logic [1:0] {
    AFT_RETRY,
    AFT_OK,
    AFT_TMO
  } after_e;

endpackage

// File: rtl/ackpoll_rst_sync.sv
module ackpoll_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ackpoll_poll_cnt.sv
module ackpoll_poll_cnt #(
  parameter int unsigned MAX_POLLS = 8,
  localparam int unsigned CNT_W    = $clog2(MAX_POLLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             at_limit
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_POLLS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | (inc & (cnt_q != LIMIT));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count    = cnt_q;
  assign at_limit = (cnt_q == LIMIT);
endmodule

// File: rtl/ackpoll_cmd_gen.sv
module ackpoll_cmd_gen
  import ackpoll_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  state_e            state,
  input  logic [BYTE_W-2:0] dev_q,
  input  logic [BYTE_W-1:0] waddr_q,
  output logic              cmd_valid,
  output cmd_e              cmd_code,
  output logic [BYTE_W-1:0] cmd_byte
);
  always_comb begin
    cmd_valid = 1'b1;
    cmd_code  = CMD_NONE;
    cmd_byte  = '0;
    case (state)
      ST_ISS_START: cmd_code = CMD_START;
      ST_ISS_ADDR: begin
        cmd_code = CMD_BYTE;
        cmd_byte = {dev_q, 1'b0};
      end
      ST_ISS_WADDR: begin
        cmd_code = CMD_BYTE;
        cmd_byte = waddr_q;
      end
      ST_ISS_STOP:  cmd_code = CMD_STOP;
      default:      cmd_valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/ackpoll_fsm.sv
module ackpoll_fsm
  import ackpoll_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go,
  input  logic   cmd_done,
  input  logic   cmd_ack,
  input  logic   wr_next,
  input  logic   at_limit,
  output state_e state,
  output logic   cnt_clr,
  output logic   cnt_inc,
  output logic   done,
  output logic   ok,
  output logic   timeout
);
  state_e state_q, state_d;
  after_e after_q, after_d;
  logic   fin_ok, fin_tmo;
  logic   stat_en;

  always_comb begin
    state_d = state_q;
    after_d = after_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    fin_ok  = 1'b0;
    fin_tmo = 1'b0;
    case (state_q)
      ST_IDLE: if (go) begin
        state_d = ST_ISS_START;
        cnt_clr = 1'b1;
      end
      ST_ISS_START: state_d = ST_W_START;
      ST_W_START:   if (cmd_done) state_d = ST_ISS_ADDR;
      ST_ISS_ADDR: begin
        state_d = ST_W_ADDR;
        cnt_inc = 1'b1;
      end
      ST_W_ADDR: if (cmd_done) begin
        if (cmd_ack && wr_next) begin
          state_d = ST_ISS_WADDR;
        end else begin
          state_d = ST_ISS_STOP;
          if (cmd_ack)       after_d = AFT_OK;
          else if (at_limit) after_d = AFT_TMO;
          else               after_d = AFT_RETRY;
        end
      end
      ST_ISS_WADDR: state_d = ST_W_WADDR;
      ST_W_WADDR: if (cmd_done) begin
        state_d = ST_IDLE;
        fin_ok  = 1'b1;
      end
      ST_ISS_STOP: state_d = ST_W_STOP;
      ST_W_STOP: if (cmd_done) begin
        case (after_q)
          AFT_OK: begin
            state_d = ST_IDLE;
            fin_ok  = 1'b1;
          end
          AFT_TMO: begin
            state_d = ST_IDLE;
            fin_tmo = 1'b1;
          end
          default: state_d = ST_ISS_START;
        endcase
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      after_q <= AFT_RETRY;
    end else begin
      state_q <= state_d;
      after_q <= after_d;
    end
  end

  assign stat_en = cnt_clr | fin_ok | fin_tmo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      ok      <= 1'b0;
      timeout <= 1'b0;
    end else begin
      done <= fin_ok | fin_tmo;
      if (stat_en) begin
        ok      <= fin_ok;
        timeout <= fin_tmo;
      end
    end
  end

  assign state = state_q;
endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
  import ackpoll_pkg::*;
#(
  parameter int unsigned MAX_POLLS = 8,
  parameter int unsigned BYTE_W    = 8,
  localparam int unsigned CNT_W    = $clog2(MAX_POLLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              next_is_write,
  input  logic [BYTE_W-2:0] dev_addr,
  input  logic [BYTE_W-1:0] byte_addr,
  output logic              cmd_valid,
  output logic [1:0]        cmd_code,
  output logic [BYTE_W-1:0] cmd_byte,
  input  logic              cmd_done,
  input  logic              cmd_ack,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic              timeout,
  output logic [CNT_W-1:0]  attempts
);
  logic              rst_int_n;
  state_e            state;
  logic              cnt_clr, cnt_inc, at_limit;
  logic [BYTE_W-2:0] dev_q;
  logic [BYTE_W-1:0] waddr_q;
  logic              wr_q;
  cmd_e              code_e;

  ackpoll_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // operands captured only when a run is accepted
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dev_q   <= '0;
      waddr_q <= '0;
      wr_q    <= 1'b0;
    end else if (cnt_clr) begin
      dev_q   <= dev_addr;
      waddr_q <= byte_addr;
      wr_q    <= next_is_write;
    end
  end

  ackpoll_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .go       (go),
    .cmd_done (cmd_done),
    .cmd_ack  (cmd_ack),
    .wr_next  (wr_q),
    .at_limit (at_limit),
    .state    (state),
    .cnt_clr  (cnt_clr),
    .cnt_inc  (cnt_inc),
    .done     (done),
    .ok       (ok),
    .timeout  (timeout)
  );

  ackpoll_poll_cnt #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .count    (attempts),
    .at_limit (at_limit)
  );

  ackpoll_cmd_gen #(.BYTE_W(BYTE_W)) u_cmd (
    .state     (state),
    .dev_q     (dev_q),
    .waddr_q   (waddr_q),
    .cmd_valid (cmd_valid),
    .cmd_code  (code_e),
    .cmd_byte  (cmd_byte)
  );

  assign cmd_code = code_e;
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/ackpoll_seq_chk.sv
module ackpoll_seq_chk #(
  parameter int unsigned MAX_POLLS = 8,
  localparam int unsigned CNT_W    = $clog2(MAX_POLLS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             busy,
  input logic             cmd_valid,
  input logic [1:0]       cmd_code,
  input logic             cmd_done,
  input logic             done,
  input logic             ok,
  input logic             timeout,
  input logic [CNT_W-1:0] attempts
);
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  assert_first_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cmd_valid && cmd_code == 2'd1));

  assert_single_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_end_on_reply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cmd_done));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_attempts_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> $stable(attempts));

  assert_status_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok != timeout));

  assert_attempt_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    attempts <= CNT_W'(MAX_POLLS));
endmodule

bind ackpoll_seq ackpoll_seq_chk #(.MAX_POLLS(MAX_POLLS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .go        (go),
  .busy      (busy),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .cmd_done  (cmd_done),
  .done      (done),
  .ok        (ok),
  .timeout   (timeout),
  .attempts  (attempts)
);

// File: tb/ackpoll_seq_tb.sv
`timescale 1ns/1ps
module ackpoll_seq_tb_top;
  localparam int MAXP  = 8;
  localparam int BW    = 8;
  localparam int CW    = $clog2(MAXP + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          go, next_is_write;
  logic [BW-2:0] dev_addr;
  logic [BW-1:0] byte_addr;
  logic          cmd_valid;
  logic [1:0]    cmd_code;
  logic [BW-1:0] cmd_byte;
  logic          cmd_done, cmd_ack;
  logic          busy, done, ok, timeout;
  logic [CW-1:0] attempts;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ackpoll_seq #(.MAX_POLLS(MAXP), .BYTE_W(BW)) dut_i (.*);

  // expected command stream: code*256 + byte
  int   exp_q[$];
  int   busy_left;
  int   lat;
  int   pend;
  logic pend_ack;
  logic prev_start;
  logic got_done;
  logic exp_ok, exp_tmo;
  int   exp_att;
  logic [BW-2:0] run_dev;
  logic          responder_on;

  task automatic chk(input bit cond, input string req, input int act, input int expv);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // byte master model with a busy device behind it
  initial begin
    cmd_done = 1'b0; cmd_ack = 1'b0; pend = 0; pend_ack = 1'b0;
    prev_start = 1'b0; got_done = 1'b0;
    forever begin
      @(negedge clk);
      cmd_done = 1'b0; cmd_ack = 1'b0;
      if (responder_on) begin
        if (pend > 0) begin
          pend--;
          if (pend == 0) begin cmd_done = 1'b1; cmd_ack = pend_ack; end
        end
        if (cmd_valid) begin
          int expv, act;
          chk(pend == 0 && !cmd_done, "R9 command while previous pending", pend, 0);
          act = (cmd_code == 2'd2) ? (int'(cmd_code) * 256 + int'(cmd_byte)) : int'(cmd_code) * 256;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3/R4/R5/R6 unexpected command", act, -1);
          end else begin
            expv = exp_q.pop_front();
            chk(act == expv, "R3/R4/R5/R6/R7 command stream", act, expv);
          end
          pend = lat;
          pend_ack = 1'b1;
          if (cmd_code == 2'd2 && prev_start) begin
            pend_ack = (busy_left == 0);
            if (busy_left > 0) busy_left--;
          end
          prev_start = (cmd_code == 2'd1);
        end
        if (done) begin
          got_done = 1'b1;
          chk(ok == exp_ok, "R5/R6/R7 ok", int'(ok), int'(exp_ok));
          chk(timeout == exp_tmo, "R7 timeout", int'(timeout), int'(exp_tmo));
          chk(int'(attempts) == exp_att, "R8 attempts", int'(attempts), exp_att);
        end
      end else if (cmd_valid) begin
        chk(1'b0, "R1 command while idle", 1, 0);
      end
    end
  end

  task automatic run(input int nbusy, input bit wr, input logic [BW-2:0] dv,
                     input logic [BW-1:0] ba, input int l, input bit interfere);
    int cyc;
    exp_q.delete();
    busy_left = nbusy; lat = l; got_done = 1'b0; prev_start = 1'b0;
    run_dev = dv;
    if (nbusy < MAXP) begin
      for (int i = 0; i < nbusy; i++) begin
        exp_q.push_back(256); exp_q.push_back(512 + int'({dv, 1'b0})); exp_q.push_back(768);
      end
      exp_q.push_back(256); exp_q.push_back(512 + int'({dv, 1'b0}));
      if (wr) exp_q.push_back(512 + int'(ba)); // R5 no stop before word address
      else    exp_q.push_back(768);            // R6 stop on read exit
      exp_ok = 1'b1; exp_tmo = 1'b0; exp_att = nbusy + 1;
    end else begin
      for (int i = 0; i < MAXP; i++) begin
        exp_q.push_back(256); exp_q.push_back(512 + int'({dv, 1'b0})); exp_q.push_back(768);
      end
      exp_ok = 1'b0; exp_tmo = 1'b1; exp_att = MAXP;  // R7
    end
    @(negedge clk);
    go = 1'b1; next_is_write = wr; dev_addr = dv; byte_addr = ba;
    @(negedge clk);
    go = 1'b0;
    // R2: operands change after capture
    next_is_write = ~wr; dev_addr = ~dv; byte_addr = ~ba;
    if (interfere) begin
      repeat (5) @(negedge clk);
      go = 1'b1;  // R10: ignored while busy
      @(negedge clk);
      go = 1'b0;
    end
    cyc = 0;
    while (!got_done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(got_done, "R8 done seen", int'(got_done), 1);
    chk(exp_q.size() == 0, "R4/R7 all commands issued", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    chk(!done && !busy, "R8 done one pulse then idle", int'(done), 0);
    chk(int'(attempts) == exp_att && ok == exp_ok && timeout == exp_tmo,
        "R8 status held", int'(attempts), exp_att);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    responder_on = 1'b0;
    rst_n = 1'b0; go = 1'b0; next_is_write = 1'b0; dev_addr = '0; byte_addr = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !cmd_valid && !done && !ok && !timeout && attempts == 0,
        "R1 reset state", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && attempts == 0, "R1 after release", int'(attempts), 0);
    // R1: stray completion while idle must not start anything
    cmd_done = 1'b1; cmd_ack = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0; cmd_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !cmd_valid, "R1 stray done ignored", int'(busy), 0);
    responder_on = 1'b1;

    run(0, 1'b1, 7'h50, 8'h3C, 1, 1'b0);        // R5 immediate ready, write
    run(0, 1'b0, 7'h51, 8'h00, 2, 1'b0);        // R6 immediate ready, read
    run(3, 1'b1, 7'h55, 8'hA7, 3, 1'b1);        // R4 R10 retries, write
    run(5, 1'b0, 7'h2A, 8'h11, 1, 1'b0);        // R4 retries, read
    run(MAXP-1, 1'b1, 7'h57, 8'hF0, 2, 1'b0);   // R7 boundary: last try succeeds
    run(MAXP, 1'b1, 7'h50, 8'h01, 1, 1'b0);     // R7 exactly cap
    run(20, 1'b0, 7'h7F, 8'h80, 3, 1'b1);       // R7 R10 far beyond cap
    run(1, 1'b0, 7'h00, 8'h5A, 1, 1'b0);        // R3 address with zero bits

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule